// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel PCM words into a serial bit stream. An external bit clock and frame sync are both sampled in the system clock domain. A frame holds one or two phases. Each phase has its own word count and its own word length. The first data bit of a frame follows the frame sync by a programmable delay. Configuration bits select the bit-clock edge on which data is launched and the active level of the frame sync.

Software or a DMA engine writes one word at a time into a single-entry holding register. A ready/empty handshake guards that register. The shifter takes the next word at the start of every word slot. If the register is empty at that point, the previous word is sent again and a sticky underrun flag is raised. A frame sync can arrive before the current frame has finished. Such a sync either restarts the frame and raises a sticky sync-error flag, or it is ignored, depending on a configuration bit.

A run control holds the shifter idle while it is low. Dropping it also clears both sticky flags.

Top module: `sat_tx`

## Requirements
- R1: The word-length code sets the bits per word: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32, and codes 6 and 7 also give 32. Each word is taken from the low N bits of `wr_data` and is sent MSB first.
- R2: A phase carries its count field plus one words. When `cfg_dual` is 0, a frame is phase 0 alone.
- R3: When `cfg_dual` is 1, phase 1 starts in the bit period right after the last bit of phase 0. Phase 1 uses `cfg_len1` and `cfg_cnt1`.
- R4: Call the bit period in which a sync event is sampled period S. With `cfg_delay`=0 the first data bit occupies period S+1. With `cfg_delay`=1 it occupies period S+2.
- R5: With `cfg_clk_pol`=1, data is launched on falling `sclk_in` edges and the frame sync is sampled on rising edges. With `cfg_clk_pol`=0 both edges swap. `sd_out` changes on no other edge.
- R6: With `cfg_fs_pol`=0 the sync is active high, and with 1 it is active low. A sync event is an inactive-to-active change between two successive sampling edges, so a sync held active for several periods starts one frame.
- R7: `sd_out` is 0 whenever no word bit is being sent: while idle, during the delay period, and after a frame ends.
- R8: With `cfg_fs_ignore`=0, a sync event before the frame's last bit period sets the sticky `sync_err` and restarts the frame from the new sync. A sync in the last bit period starts the next frame without error.
- R9: With `cfg_fs_ignore`=1, a sync event inside a frame has no effect, the frame completes unchanged, and `sync_err` stays 0.
- R10: If the holding register is empty when a word slot begins, the last word sent is repeated and the sticky `underrun` flag is set.
- R11: `wr_ready` is 1 exactly when the holding register is empty. A write with `wr_valid` and `wr_ready` both high fills it. A word slot start empties it.
- R12: While `tx_run` is 0, `sd_out` stays 0, no frame starts, and `underrun` and `sync_err` clear. After `rst`, all outputs are 0 except `wr_ready`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_run | input | 1 | Run control; 0 holds the shifter idle and clears the flags |
| cfg_dual | input | 1 | 1 selects a two-phase frame |
| cfg_len0 | input | 3 | Word-length code, phase 0 |
| cfg_cnt0 | input | CNT_W | Words in phase 0, minus one |
| cfg_len1 | input | 3 | Word-length code, phase 1 |
| cfg_cnt1 | input | CNT_W | Words in phase 1, minus one |
| cfg_delay | input | 1 | Data delay after sync, 0 or 1 bit |
| cfg_clk_pol | input | 1 | 1: launch on falling bit-clock edge |
| cfg_fs_pol | input | 1 | 1: frame sync active low |
| cfg_fs_ignore | input | 1 | 1: ignore syncs inside a frame |
| sclk_in | input | 1 | Bit clock |
| fs_in | input | 1 | Frame sync |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to send, right-justified |
| wr_ready | output | 1 | Holding register empty |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |
| sync_err | output | 1 | Sticky unexpected-sync flag |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- The line is low and both flags are clear while the run control is low.
- `sd_out` moves only in the cycle after a launch edge.
- Both flags stay set once raised.
- No sync error appears while ignore mode is on.
- A write fills the holding register.
- An underrun rises only when the register was empty.

Other behaviour can only be seen by comparing whole frames bit by bit against a model of the requirements. This covers bit order and word length per code, the phase sequence, the one-period shift of the delay, launch timing under each clock polarity, the repeated word on underrun, and the exact restart point after an early sync. The bench shows these through directed and random frame scenarios, including a second sync placed in the last bit period of a frame.

// File: rtl/sat_pkg.sv
package sat_pkg;

    // Largest word the shifter handles; word-length codes never exceed this.
    localparam int unsigned WORD_MAX = 32;

    // Bits per word for a 3-bit length code (codes above 5 saturate at 32).
    function automatic logic [5:0] wlen_bits(input logic [2:0] code);
        logic [5:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd3:    n = 6'd20;
            3'd4:    n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

    // Single-cycle events derived from the bit clock and frame sync.
    typedef struct packed {
        logic drive;   // launch edge of the bit clock
        logic sample;  // sampling edge of the bit clock
        logic sync;    // new frame sync seen at a sampling edge
    } edge_ev_t;

    // Static frame layout settings.
    typedef struct packed {
        logic       dual;
        logic [2:0] code0;
        logic [2:0] code1;
        logic       delay;
        logic       ignore;
    } frame_mode_t;

endpackage

// File: rtl/sat_edge_detect.sv
module sat_edge_detect
    import sat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_in,
    input  logic     fs_in,
    input  logic     clk_pol,
    input  logic     fs_pol,
    output edge_ev_t ev
);

    logic sclk_q;
    logic fs_seen;
    logic rise;
    logic fall;
    logic fs_act;

    always_comb begin
        rise      = sclk_in & ~sclk_q;
        fall      = ~sclk_in & sclk_q;
        fs_act    = fs_in ^ fs_pol;
        ev.drive  = clk_pol ? fall : rise;
        ev.sample = clk_pol ? rise : fall;
        ev.sync   = ev.sample & fs_act & ~fs_seen;
    end

    always_ff @(posedge clk) begin
        sclk_q <= sclk_in;
        if (rst) begin
            fs_seen <= 1'b0;
        end else if (ev.sample) begin
            fs_seen <= fs_act;
        end
    end

endmodule

// File: rtl/sat_hold_reg.sv
module sat_hold_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              wr_ready,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    assign wr_ready = ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take) begin
                full <= 1'b0;
            end
            if (wr_valid && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sat_framer.sv
module sat_framer
    import sat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_run,
    input  edge_ev_t          ev,
    input  frame_mode_t       mode,
    input  logic [CNT_W-1:0]  cnt0,
    input  logic [CNT_W-1:0]  cnt1,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              sd_out,
    output logic              underrun,
    output logic              sync_err,
    output logic              busy
);

    localparam int IDX_W = $clog2(DATA_W);

    tx_state_e         st;
    logic              wait_cnt;
    logic              phase;
    logic [CNT_W-1:0]  word_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] sreg;

    logic [CNT_W-1:0]  cur_words_m1;
    logic              last_word;
    logic              last_phase;
    logic              word_end;
    logic              frame_end;
    logic              sync_hit;
    logic              restart;
    logic              collide;
    logic              first_slot;
    logic              next_slot;
    logic              slot_go;
    logic              nxt_phase;
    logic [CNT_W-1:0]  nxt_word;
    logic [5:0]        nxt_bits;
    logic [IDX_W-1:0]  nxt_idx;
    logic [DATA_W-1:0] nxt_data;

    always_comb begin
        cur_words_m1 = phase ? cnt1 : cnt0;
        last_word    = (word_cnt == cur_words_m1);
        last_phase   = !mode.dual || phase;
        word_end     = (st == ST_SHIFT) && (bit_idx == '0);
        frame_end    = word_end && last_word && last_phase;
        busy         = (st == ST_WAIT) || ((st == ST_SHIFT) && !frame_end);

        sync_hit     = tx_run && ev.sync;
        restart      = sync_hit && (!busy || !mode.ignore);
        collide      = sync_hit && busy && !mode.ignore;

        first_slot   = ev.drive && (st == ST_WAIT) && !wait_cnt;
        next_slot    = ev.drive && word_end && !frame_end;
        slot_go      = tx_run && !restart && (first_slot || next_slot);

        nxt_phase    = first_slot ? 1'b0 : (last_word ? 1'b1 : phase);
        nxt_word     = (first_slot || last_word) ? '0 : word_cnt + 1'b1;
        nxt_bits     = wlen_bits(nxt_phase ? mode.code1 : mode.code0);
        nxt_idx      = IDX_W'(nxt_bits - 6'd1);
        nxt_data     = hold_full ? hold_data : sreg;
        take         = slot_go && hold_full;
    end

    // Last loaded word; kept on underrun so it is sent again.
    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (slot_go) begin
            sreg <= nxt_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_run) begin
            st       <= ST_IDLE;
            wait_cnt <= 1'b0;
            phase    <= 1'b0;
            word_cnt <= '0;
            bit_idx  <= '0;
            sd_out   <= 1'b0;
            underrun <= 1'b0;
            sync_err <= 1'b0;
        end else if (restart) begin
            st       <= ST_WAIT;
            wait_cnt <= mode.delay;
            if (collide) begin
                sync_err <= 1'b1;
            end
        end else if (slot_go) begin
            st       <= ST_SHIFT;
            phase    <= nxt_phase;
            word_cnt <= nxt_word;
            bit_idx  <= nxt_idx;
            sd_out   <= nxt_data[nxt_idx];
            if (!hold_full) begin
                underrun <= 1'b1;
            end
        end else if (ev.drive) begin
            case (st)
                ST_WAIT: begin
                    wait_cnt <= 1'b0;
                    sd_out   <= 1'b0;
                end
                ST_SHIFT: begin
                    if (bit_idx != '0) begin
                        bit_idx <= bit_idx - 1'b1;
                        sd_out  <= sreg[bit_idx - 1'b1];
                    end else begin
                        st     <= ST_IDLE;
                        sd_out <= 1'b0;
                    end
                end
                default: begin
                    sd_out <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sat_tx.sv
module sat_tx
    import sat_pkg::*;
#(
    parameter int DATA_W = WORD_MAX,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_run,
    input  logic              cfg_dual,
    input  logic [2:0]        cfg_len0,
    input  logic [CNT_W-1:0]  cfg_cnt0,
    input  logic [2:0]        cfg_len1,
    input  logic [CNT_W-1:0]  cfg_cnt1,
    input  logic              cfg_delay,
    input  logic              cfg_clk_pol,
    input  logic              cfg_fs_pol,
    input  logic              cfg_fs_ignore,
    input  logic              sclk_in,
    input  logic              fs_in,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              sd_out,
    output logic              underrun,
    output logic              sync_err
);

    edge_ev_t          ev;
    frame_mode_t       mode;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              frame_busy;

    always_comb begin
        mode.dual   = cfg_dual;
        mode.code0  = cfg_len0;
        mode.code1  = cfg_len1;
        mode.delay  = cfg_delay;
        mode.ignore = cfg_fs_ignore;
    end

    sat_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .sclk_in (sclk_in),
        .fs_in   (fs_in),
        .clk_pol (cfg_clk_pol),
        .fs_pol  (cfg_fs_pol),
        .ev      (ev)
    );

    sat_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .wr_ready (wr_ready),
        .full     (hold_full),
        .data     (hold_data)
    );

    sat_framer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .tx_run    (tx_run),
        .ev        (ev),
        .mode      (mode),
        .cnt0      (cfg_cnt0),
        .cnt1      (cfg_cnt1),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .sd_out    (sd_out),
        .underrun  (underrun),
        .sync_err  (sync_err),
        .busy      (frame_busy)
    );

endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_run,
    input logic cfg_fs_ignore,
    input logic drive_evt,
    input logic frame_busy,
    input logic wr_valid,
    input logic wr_ready,
    input logic sd_out,
    input logic underrun,
    input logic sync_err
);

    AST_HELD_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        !tx_run |=> (sd_out == 1'b0)); // R12

    AST_HELD_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !tx_run |=> (!underrun && !sync_err)); // R12

    AST_LINE_MOVES_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (tx_run && !drive_evt) |=> $stable(sd_out)); // R5

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tx_run && underrun) |=> underrun); // R10

    AST_UNDERRUN_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(wr_ready)); // R10

    AST_SYNCERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tx_run && sync_err) |=> sync_err); // R8

    AST_SYNCERR_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_err) |-> $past(frame_busy)); // R8

    AST_IGNORE_NO_ERROR: assert property (@(posedge clk) disable iff (rst)
        (cfg_fs_ignore && !sync_err) |=> !sync_err); // R9

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> !wr_ready); // R11

endmodule

bind sat_tx sat_tx_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_run        (tx_run),
    .cfg_fs_ignore (cfg_fs_ignore),
    .drive_evt     (ev.drive),
    .frame_busy    (frame_busy),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .sd_out        (sd_out),
    .underrun      (underrun),
    .sync_err      (sync_err)
);

// File: tb/sat_tx_tb.sv
module sat_tx_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        tx_run = 1'b1;
    logic        cfg_dual = 1'b0;
    logic [2:0]  cfg_len0 = 3'd2;
    logic [6:0]  cfg_cnt0 = 7'd1;
    logic [2:0]  cfg_len1 = 3'd2;
    logic [6:0]  cfg_cnt1 = 7'd0;
    logic        cfg_delay = 1'b1;
    logic        cfg_clk_pol = 1'b0;
    logic        cfg_fs_pol = 1'b0;
    logic        cfg_fs_ignore = 1'b0;
    logic        sclk_in = 1'b0;
    logic        fs_in = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        sd_out;
    logic        underrun;
    logic        sync_err;

    sat_tx u_dut (
        .clk(clk), .rst(rst), .tx_run(tx_run),
        .cfg_dual(cfg_dual), .cfg_len0(cfg_len0), .cfg_cnt0(cfg_cnt0),
        .cfg_len1(cfg_len1), .cfg_cnt1(cfg_cnt1), .cfg_delay(cfg_delay),
        .cfg_clk_pol(cfg_clk_pol), .cfg_fs_pol(cfg_fs_pol),
        .cfg_fs_ignore(cfg_fs_ignore), .sclk_in(sclk_in), .fs_in(fs_in),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .sd_out(sd_out), .underrun(underrun), .sync_err(sync_err)
    );

    localparam int SLOTS = 1024;

    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;
    logic exp_b [0:SLOTS-1];
    logic rx_b  [0:SLOTS-1];
    logic fs_p  [0:SLOTS-1];
    logic [31:0] feed [0:15];
    int   feed_n = 0;
    int   feed_idx = 0;
    int   nxt_w = 0;

    function automatic int wbits(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] word_at(input int k);
        if (feed_n == 0) return 32'd0;
        if (k < feed_n) return feed[k];
        return feed[feed_n-1];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // One system clock; refills the holding register from the feed list.
    task automatic tick();
        @(negedge clk);
        wr_valid = 1'b0;
        if (wr_ready && feed_idx < feed_n) begin
            wr_valid = 1'b1;
            wr_data  = feed[feed_idx];
            feed_idx++;
        end
    endtask

    task automatic clear_pat();
        for (int k = 0; k < SLOTS; k++) begin
            exp_b[k] = 1'b0;
            rx_b[k]  = 1'b0;
            fs_p[k]  = 1'b0;
        end
        nxt_w = 0;
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        tx_run   = 1'b1;
        wr_valid = 1'b0;
        feed_n   = 0;
        feed_idx = 0;
        sclk_in  = cfg_clk_pol;
        fs_in    = cfg_fs_pol;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    // Expected bit stream for a frame whose sync is sampled in period s.
    task automatic add_frame(input int s, output int end_slot);
        int slot;
        slot = s + 1 + int'(cfg_delay);
        for (int ph = 0; ph < (cfg_dual ? 2 : 1); ph++) begin
            int nw;
            int nb;
            nw = (ph == 0) ? int'(cfg_cnt0) + 1 : int'(cfg_cnt1) + 1;
            nb = (ph == 0) ? wbits(cfg_len0) : wbits(cfg_len1);
            for (int w = 0; w < nw; w++) begin
                logic [31:0] word;
                word = word_at(nxt_w);
                nxt_w++;
                for (int b = nb - 1; b >= 0; b--) begin
                    exp_b[slot] = word[b];
                    slot++;
                end
            end
        end
        end_slot = slot;
    endtask

    // Bit periods of 8 system clocks: launch edge, then sampling edge.
    task automatic run_slots(input int n);
        for (int k = 0; k < n; k++) begin
            tick();
            sclk_in = ~cfg_clk_pol;
            fs_in   = fs_p[k] ^ cfg_fs_pol;
            repeat (3) tick();
            tick();
            rx_b[k] = sd_out;
            sclk_in = cfg_clk_pol;
            repeat (3) tick();
        end
    endtask

    task automatic cmp_bits(input int n, input string req);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int k = 0; k < n; k++) begin
            if (rx_b[k] !== exp_b[k]) begin
                bad++;
                if (first < 0) first = k;
            end
        end
        if (first >= 0)
            $display("  first mismatch at period %0d: got %0b want %0b",
                     first, rx_b[first], exp_b[first]);
        check(bad == 0, req, "serial bit mismatches", bad, 0);
    endtask

    task automatic fill_feed(input int n);
        for (int k = 0; k < 16; k++) feed[k] = $urandom;
        feed_idx = 0;
        feed_n   = n;
    endtask

    initial begin
        int e1;
        int e2;
        void'($urandom(32'd20240611));

        // Reset state
        do_reset();
        check(sd_out == 1'b0, "R12", "sd_out after reset", sd_out, 0);
        check(wr_ready == 1'b1, "R11", "wr_ready after reset", wr_ready, 1);
        check(underrun == 1'b0, "R12", "underrun after reset", underrun, 0);
        check(sync_err == 1'b0, "R12", "sync_err after reset", sync_err, 0);

        // R1 R2 R4 R7: single phase, two 16-bit words, delay 1, rising launch
        cfg_dual = 0; cfg_len0 = 3'd2; cfg_cnt0 = 7'd1; cfg_delay = 1;
        cfg_clk_pol = 0; cfg_fs_pol = 0; cfg_fs_ignore = 0;
        do_reset(); clear_pat(); fill_feed(16);
        fs_p[2] = 1'b1;
        add_frame(2, e1);
        run_slots(e1 + 4);
        cmp_bits(e1 + 4, "R1/R2/R4/R7 single phase");
        check(underrun == 1'b0, "R10", "underrun with data fed", underrun, 0);

        // R3 R5 R6: dual phase, falling launch, active-low sync held 2 periods
        cfg_dual = 1; cfg_len0 = 3'd0; cfg_cnt0 = 7'd0; cfg_len1 = 3'd4;
        cfg_cnt1 = 7'd1; cfg_delay = 0; cfg_clk_pol = 1; cfg_fs_pol = 1;
        do_reset(); clear_pat(); fill_feed(16);
        fs_p[2] = 1'b1; fs_p[3] = 1'b1;
        add_frame(2, e1);
        run_slots(e1 + 4);
        cmp_bits(e1 + 4, "R3/R5/R6 dual phase");
        check(sync_err == 1'b0, "R6", "wide sync counted once", sync_err, 0);

        // Random layouts, second frame synced in the last bit period (R8 edge)
        for (int it = 0; it < 10; it++) begin
            cfg_dual    = 1'($urandom_range(0, 1));
            cfg_len0    = 3'($urandom_range(0, 7));
            cfg_len1    = 3'($urandom_range(0, 7));
            cfg_cnt0    = 7'($urandom_range(0, 2));
            cfg_cnt1    = 7'($urandom_range(0, 2));
            cfg_delay   = 1'($urandom_range(0, 1));
            cfg_clk_pol = 1'($urandom_range(0, 1));
            cfg_fs_pol  = 1'($urandom_range(0, 1));
            cfg_fs_ignore = 1'b0;
            do_reset(); clear_pat(); fill_feed(16);
            fs_p[2] = 1'b1;
            add_frame(2, e1);
            fs_p[e1-1] = 1'b1;
            add_frame(e1 - 1, e2);
            run_slots(e2 + 3);
            cmp_bits(e2 + 3, "R1/R2/R3/R4/R5/R6 random");
            check(sync_err == 1'b0, "R8", "sync in last bit period", sync_err, 0);
            check(underrun == 1'b0, "R10", "no underrun when fed", underrun, 0);
        end

        // R8: early sync restarts the frame and raises sync_err
        cfg_dual = 0; cfg_len0 = 3'd2; cfg_cnt0 = 7'd1; cfg_delay = 1;
        cfg_clk_pol = 0; cfg_fs_pol = 0; cfg_fs_ignore = 0;
        do_reset(); clear_pat(); fill_feed(16);
        fs_p[2] = 1'b1; fs_p[10] = 1'b1;
        add_frame(2, e1);
        for (int k = 11; k < SLOTS; k++) exp_b[k] = 1'b0;
        nxt_w = 1;
        add_frame(10, e2);
        run_slots(e2 + 4);
        cmp_bits(e2 + 4, "R8 restart");
        check(sync_err == 1'b1, "R8", "sync_err after early sync", sync_err, 1);
        run_slots(6);
        check(sync_err == 1'b1, "R8", "sync_err sticky", sync_err, 1);
        tx_run = 1'b0;
        tick(); tick();
        check(sync_err == 1'b0, "R12", "sync_err cleared by run low", sync_err, 0);
        tx_run = 1'b1;

        // R9: same early sync ignored
        cfg_fs_ignore = 1;
        do_reset(); clear_pat(); fill_feed(16);
        fs_p[2] = 1'b1; fs_p[10] = 1'b1;
        add_frame(2, e1);
        run_slots(e1 + 4);
        cmp_bits(e1 + 4, "R9 ignore");
        check(sync_err == 1'b0, "R9", "sync_err with ignore", sync_err, 0);

        // R10: only one word supplied; the second slot repeats it
        cfg_fs_ignore = 0;
        do_reset(); clear_pat(); fill_feed(1);
        fs_p[2] = 1'b1;
        add_frame(2, e1);
        run_slots(e1 + 4);
        cmp_bits(e1 + 4, "R10 repeat");
        check(underrun == 1'b1, "R10", "underrun flag", underrun, 1);
        check(wr_ready == 1'b1, "R11", "register empty after use", wr_ready, 1);

        // R12 R11: run low blocks frames; written word stays held
        do_reset(); clear_pat(); fill_feed(1);
        tx_run = 1'b0;
        fs_p[2] = 1'b1;
        run_slots(40);
        cmp_bits(40, "R12 held idle");
        check(wr_ready == 1'b0, "R11", "word held, not consumed", wr_ready, 0);
        check(underrun == 1'b0, "R12", "no underrun while held", underrun, 0);
        tx_run = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule